// File: doc/BRIEF.md
# Clock Watchdog With Recovery Reset

This block guards a system against hanging after its clock frequency has been changed. Software arms the watchdog with an enable bit; the countdown itself starts only when a frequency-change event arrives. The countdown runs in units of a selectable length. The unit length is either a short unit or a long unit, each measured as a parameterized number of base ticks. The number of units is the stored 5-bit timeout value plus one, so a timeout spans 1 to 32 units.

When the countdown expires, the block sets a sticky timeout status bit. In the same cycle it raises a one-cycle request to switch the clock generator to its recovery frequency. If resetting on timeout is enabled, it also drives an active-low system reset pulse. A separate option produces the same reset pulse on every frequency change. Software clears the status by writing one to it. The reset output is meant to drive an open-drain pad: low means pull down, high means release.

Top module: `clk_wdg_recovery`

## Requirements
- R1: After reset the status, the recovery request and the reset drive are inactive (status 0, request 0, reset output 1). The stored timeout value is 31 and the stored prescaler select is 0.
- R2: While the enable is 0 the timer does not run. A frequency change and any number of base ticks then produce no timeout.
- R3: With prescaler select 0, a frequency change with the enable at 1 loads (value+1) units of SHORT_TICKS base ticks each. The status is still 0 after one tick fewer than that product and becomes 1 on the clock edge that samples the last tick.
- R4: With prescaler select 1, each unit is LONG_TICKS base ticks and the timeout follows the same rule as R3.
- R5: The timeout status is sticky. It stays 1 through further ticks, frequency changes and disabling until software clears it.
- R6: A status write whose data bit is 1 clears the status. A status write whose data bit is 0 leaves it unchanged.
- R7: The recovery request is high for exactly the one cycle in which the status rises.
- R8: With reset-on-timeout set, the reset output goes low in the cycle the status rises and stays low for RST_LEN cycles. With it clear, a timeout leaves the reset output high.
- R9: With reset-on-frequency-change set, every frequency change drives the reset output low for RST_LEN cycles starting the cycle after the event, whether or not the watchdog is enabled.
- R10: A frequency change during a countdown restarts the full count.
- R11: After a timeout the timer stops, and no further timeout occurs without a new frequency change. A new frequency change rearms it.
- R12: Dropping the enable mid-count abandons the count. Raising the enable again does not resume the count; only a following frequency change starts a fresh full count.
- R13: The timeout value and the prescaler select are captured when a frequency change arrives. Configuration writes during a countdown do not alter it and take effect at the next frequency change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Base tick pulse, one clock wide |
| cfg_wr_i | input | 1 | Strobe that stores the timeout value and the prescaler select |
| cfg_val_i | input | 5 | Timeout value in units minus one |
| cfg_long_i | input | 1 | Prescaler select: 0 short unit, 1 long unit |
| wd_en_i | input | 1 | Watchdog enable |
| rst_on_tmo_i | input | 1 | Issue a reset pulse on timeout |
| rst_on_fchg_i | input | 1 | Issue a reset pulse on every frequency change |
| fchg_i | input | 1 | Frequency-change event pulse |
| status_wr_i | input | 1 | Status write strobe |
| status_wd_i | input | 1 | Status write data, 1 clears |
| tmo_status_o | output | 1 | Sticky timeout status |
| recover_o | output | 1 | One-cycle recovery-frequency request |
| rst_n_o | output | 1 | Active-low reset drive for an open-drain pad |

## Verification
Every timeout value from 0 to 31 is tried with both prescaler settings. Each run checks that the status is still clear one tick before (value+1) times the unit length and set exactly on the last tick, so an off-by-one in the unit count or the tick division shows up for every setting. Reset-on-timeout alternates across the sweep, so a reset window of the wrong length or a missing reset is caught next to runs where the reset must stay quiet. Directed patterns separate restart, disable mid-count, stop after timeout and configuration capture, each of which yields a different timeout instant.

// File: rtl/wdg_pkg.sv
// Shared widths and types for the clock watchdog.
// Assumes a 5-bit timeout value, i.e. at most 32 units per countdown.
package wdg_pkg;
    localparam int TMO_W  = 5;
    localparam int UNIT_W = $clog2((1 << TMO_W) + 1);

    typedef struct packed {
        logic [TMO_W-1:0] val;
        logic             long_sel;
    } wdg_cfg_t;
endpackage

// File: rtl/wdg_unit_div.sv
// Divides base ticks into countdown units.
// The unit length is captured on restart and the divider only counts while active.
// Assumes tick_i is one clock wide.
module wdg_unit_div #(
    parameter int SHORT_TICKS = 150,
    parameter int LONG_TICKS  = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic long_sel_i,
    input  logic active_i,
    input  logic tick_i,
    output logic unit_o
);
    localparam int MAXT  = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
    localparam int DIV_W = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [DIV_W-1:0] SHORT_LAST = DIV_W'(SHORT_TICKS - 1);
    localparam logic [DIV_W-1:0] LONG_LAST  = DIV_W'(LONG_TICKS - 1);

    logic [DIV_W-1:0] div_q;
    logic             long_q;
    logic [DIV_W-1:0] last;

    // Select the terminal count of the unit length captured at restart.
    always_comb last = long_q ? LONG_LAST : SHORT_LAST;

    assign unit_o = active_i && !restart_i && tick_i && (div_q == last);

    // Count base ticks within one unit; restart clears and captures the length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            long_q <= 1'b0;
        end else if (restart_i) begin
            div_q  <= '0;
            long_q <= long_sel_i;
        end else if (active_i && tick_i) begin
            div_q <= (div_q == last) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_countdown.sv
// Unit countdown armed by a frequency change.
// Loads value+1 units on restart, stops after expiry or when disabled.
// Assumes restart_i is already qualified by the enable.
module wdg_countdown
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [TMO_W-1:0] val_i,
    input  logic             unit_i,
    output logic             active_o,
    output logic             expire_o
);
    logic [UNIT_W-1:0] units_q;
    logic              run_q;

    assign active_o = run_q && en_i;
    assign expire_o = active_o && unit_i && (units_q == UNIT_W'(1));

    // Hold the remaining unit count and the running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            units_q <= '0;
        end else if (!en_i) begin
            run_q   <= 1'b0;
            units_q <= '0;
        end else if (restart_i) begin
            run_q   <= 1'b1;
            units_q <= UNIT_W'(val_i) + UNIT_W'(1);
        end else if (active_o && unit_i) begin
            units_q <= units_q - 1'b1;
            if (units_q == UNIT_W'(1))
                run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wdg_rst_pulse.sv
// Stretches a trigger into an active-low reset of RST_LEN clock cycles.
// A new trigger while the pulse is running reloads the full length.
module wdg_rst_pulse #(
    parameter int RST_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rst_n_o
);
    localparam int CNT_W = $clog2(RST_LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    assign rst_n_o = (cnt_q == '0);

    // Load on trigger, then count down to release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (trig_i)
            cnt_q <= CNT_W'(RST_LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/clk_wdg_recovery.sv
// Clock watchdog top: configuration store, sticky status, recovery request
// and reset generation around a frequency-change-armed countdown.
// Assumes tick_i, fchg_i and the write strobes are single-cycle pulses in clk's domain.
module clk_wdg_recovery
    import wdg_pkg::*;
#(
    parameter int SHORT_TICKS = 150,
    parameter int LONG_TICKS  = 2500,
    parameter int RST_LEN     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cfg_wr_i,
    input  logic [TMO_W-1:0] cfg_val_i,
    input  logic             cfg_long_i,
    input  logic             wd_en_i,
    input  logic             rst_on_tmo_i,
    input  logic             rst_on_fchg_i,
    input  logic             fchg_i,
    input  logic             status_wr_i,
    input  logic             status_wd_i,
    output logic             tmo_status_o,
    output logic             recover_o,
    output logic             rst_n_o
);
    wdg_cfg_t cfg_q;
    logic     restart;
    logic     active;
    logic     unit_tick;
    logic     expire;
    logic     rst_trig;

    assign restart  = wd_en_i && fchg_i;
    assign rst_trig = (expire && rst_on_tmo_i) || (fchg_i && rst_on_fchg_i);

    // Store the timeout configuration; resets to the longest short-unit timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.val      <= '1;
            cfg_q.long_sel <= 1'b0;
        end else if (cfg_wr_i) begin
            cfg_q.val      <= cfg_val_i;
            cfg_q.long_sel <= cfg_long_i;
        end
    end

    // Sticky status: expiry sets, a write of one clears, expiry wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo_status_o <= 1'b0;
        else if (expire)
            tmo_status_o <= 1'b1;
        else if (status_wr_i && status_wd_i)
            tmo_status_o <= 1'b0;
    end

    // One-cycle recovery-frequency request aligned with the status rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            recover_o <= 1'b0;
        else
            recover_o <= expire;
    end

    wdg_unit_div #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .long_sel_i(cfg_q.long_sel),
        .active_i  (active),
        .tick_i    (tick_i),
        .unit_o    (unit_tick)
    );

    wdg_countdown u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (wd_en_i),
        .restart_i(restart),
        .val_i    (cfg_q.val),
        .unit_i   (unit_tick),
        .active_o (active),
        .expire_o (expire)
    );

    wdg_rst_pulse #(
        .RST_LEN(RST_LEN)
    ) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (rst_trig),
        .rst_n_o(rst_n_o)
    );
endmodule

// File: rtl/clk_wdg_recovery_chk.sv
// Port-level temporal checks for the clock watchdog, bound to the top.
module clk_wdg_recovery_chk (
    input logic clk,
    input logic rst_n,
    input logic wd_en_i,
    input logic rst_on_tmo_i,
    input logic rst_on_fchg_i,
    input logic fchg_i,
    input logic status_wr_i,
    input logic status_wd_i,
    input logic tmo_status_o,
    input logic recover_o,
    input logic rst_n_o
);
    p_rise_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_status_o) |-> recover_o);

    p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recover_o |=> !recover_o);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wd_en_i) |-> !recover_o);

    p_clear_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_wr_i && status_wd_i) && !recover_o) |-> !tmo_status_o);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tmo_status_o) && !$past(status_wr_i && status_wd_i)) |-> tmo_status_o);

    p_tmo_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (recover_o && $past(rst_on_tmo_i)) |-> !rst_n_o);

    p_fchg_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fchg_i && rst_on_fchg_i) |-> !rst_n_o);

    p_reset_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_n_o) |-> ($past(fchg_i && rst_on_fchg_i) || (recover_o && $past(rst_on_tmo_i))));
endmodule

bind clk_wdg_recovery clk_wdg_recovery_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wd_en_i      (wd_en_i),
    .rst_on_tmo_i (rst_on_tmo_i),
    .rst_on_fchg_i(rst_on_fchg_i),
    .fchg_i       (fchg_i),
    .status_wr_i  (status_wr_i),
    .status_wd_i  (status_wd_i),
    .tmo_status_o (tmo_status_o),
    .recover_o    (recover_o),
    .rst_n_o      (rst_n_o)
);

// File: tb/clk_wdg_recovery_test.sv
// Bench: sweeps every timeout value with both unit lengths, plus directed cases.
module clk_wdg_recovery_test;
    localparam int SHORT = 3;
    localparam int LONG  = 5;
    localparam int RLEN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [4:0] cfg_val_i = '0;
    logic       cfg_long_i = 1'b0;
    logic       wd_en_i = 1'b0;
    logic       rst_on_tmo_i = 1'b0;
    logic       rst_on_fchg_i = 1'b0;
    logic       fchg_i = 1'b0;
    logic       status_wr_i = 1'b0;
    logic       status_wd_i = 1'b0;
    logic       tmo_status_o;
    logic       recover_o;
    logic       rst_n_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    clk_wdg_recovery #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .RST_LEN(RLEN)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
        .cfg_val_i(cfg_val_i), .cfg_long_i(cfg_long_i), .wd_en_i(wd_en_i),
        .rst_on_tmo_i(rst_on_tmo_i), .rst_on_fchg_i(rst_on_fchg_i), .fchg_i(fchg_i),
        .status_wr_i(status_wr_i), .status_wd_i(status_wd_i),
        .tmo_status_o(tmo_status_o), .recover_o(recover_o), .rst_n_o(rst_n_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fchg_pulse();
        fchg_i = 1'b1;
        @(negedge clk);
        fchg_i = 1'b0;
    endtask

    task automatic cfg(input logic [4:0] v, input logic l);
        cfg_val_i = v; cfg_long_i = l; cfg_wr_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic status_write(input logic d);
        status_wd_i = d; status_wr_i = 1'b1;
        @(negedge clk);
        status_wr_i = 1'b0; status_wd_i = 1'b0;
    endtask

    // Checks the reset window: low now, low for RLEN-1 more cycles, then high.
    task automatic rst_window(input string req);
        chk(req, rst_n_o, 1'b0);
        idle(RLEN - 1);
        chk(req, rst_n_o, 1'b0);
        idle(1);
        chk(req, rst_n_o, 1'b1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1 status", tmo_status_o, 1'b0);
        chk("R1 recover", recover_o, 1'b0);
        chk("R1 rst_n", rst_n_o, 1'b1);

        // R1: stored defaults are value 31 with short units
        wd_en_i = 1'b1;
        fchg_pulse();
        ticks(32 * SHORT - 1);
        chk("R1 default early", tmo_status_o, 1'b0);
        ticks(1);
        chk("R1 default expiry", tmo_status_o, 1'b1);
        chk("R7 recover", recover_o, 1'b1);
        chk("R8 no reset when off", rst_n_o, 1'b1);
        idle(1);
        chk("R7 recover single", recover_o, 1'b0);

        // R5 sticky and R6 write-zero has no effect
        ticks(10);
        fchg_pulse();
        chk("R5 sticky", tmo_status_o, 1'b1);
        status_write(1'b0);
        chk("R6 write zero", tmo_status_o, 1'b1);
        status_write(1'b1);
        chk("R6 write one", tmo_status_o, 1'b0);

        // R3/R4/R8 sweep over every value and both unit lengths
        for (int v = 0; v < 32; v++) begin
            for (int l = 0; l < 2; l++) begin
                automatic int n = (v + 1) * (l ? LONG : SHORT);
                automatic logic ron = logic'((v ^ l) & 1);
                cfg(5'(v), logic'(l));
                rst_on_tmo_i = ron;
                fchg_pulse();
                ticks(n - 1);
                chk(l ? "R4 early" : "R3 early", tmo_status_o, 1'b0);
                ticks(1);
                chk(l ? "R4 expiry" : "R3 expiry", tmo_status_o, 1'b1);
                chk("R7 recover sweep", recover_o, 1'b1);
                if (ron) rst_window("R8 timeout reset");
                else     chk("R8 reset off", rst_n_o, 1'b1);
                status_write(1'b1);
            end
        end
        rst_on_tmo_i = 1'b0;

        // R11: stopped after timeout; only a new change rearms
        cfg(5'd1, 1'b0);
        fchg_pulse();
        ticks(6);
        chk("R11 first expiry", tmo_status_o, 1'b1);
        status_write(1'b1);
        ticks(20);
        chk("R11 stays stopped", tmo_status_o, 1'b0);
        fchg_pulse();
        ticks(6);
        chk("R11 rearmed", tmo_status_o, 1'b1);
        status_write(1'b1);

        // R10: restart mid count
        fchg_pulse();
        ticks(4);
        fchg_pulse();
        ticks(5);
        chk("R10 restart early", tmo_status_o, 1'b0);
        ticks(1);
        chk("R10 restart expiry", tmo_status_o, 1'b1);
        status_write(1'b1);

        // R12: disable mid count, re-enable without change
        fchg_pulse();
        ticks(3);
        wd_en_i = 1'b0;
        idle(1);
        wd_en_i = 1'b1;
        ticks(20);
        chk("R12 no resume", tmo_status_o, 1'b0);
        fchg_pulse();
        ticks(5);
        chk("R12 fresh early", tmo_status_o, 1'b0);
        ticks(1);
        chk("R12 fresh expiry", tmo_status_o, 1'b1);
        status_write(1'b1);

        // R2: disabled timer ignores changes and ticks
        wd_en_i = 1'b0;
        fchg_pulse();
        ticks(40);
        chk("R2 disabled", tmo_status_o, 1'b0);
        chk("R2 no request", recover_o, 1'b0);

        // R9: reset on frequency change, enabled or not
        rst_on_fchg_i = 1'b1;
        fchg_pulse();
        rst_window("R9 reset disabled wd");
        wd_en_i = 1'b1;
        fchg_pulse();
        rst_window("R9 reset enabled wd");
        rst_on_fchg_i = 1'b0;
        fchg_pulse();
        chk("R9 reset off", rst_n_o, 1'b1);

        // R13: configuration captured at the change
        cfg(5'd1, 1'b0);
        fchg_pulse();
        ticks(2);
        cfg(5'd3, 1'b1);
        ticks(3);
        chk("R13 old count early", tmo_status_o, 1'b0);
        ticks(1);
        chk("R13 old count expiry", tmo_status_o, 1'b1);
        status_write(1'b1);
        fchg_pulse();
        ticks(19);
        chk("R13 new count early", tmo_status_o, 1'b0);
        ticks(1);
        chk("R13 new count expiry", tmo_status_o, 1'b1);

        finish_run();
    end
endmodule